// File: doc/BRIEF.md
# Packed Two-Entry Colour Lookup Table

This block holds a 256-entry colour lookup table for a display path. Software sees it as 128 word registers in a byte-addressed register window starting at byte offset 0x200; every 32-bit word carries two 16-bit colour entries, and the words read back exactly as written. A pixel pipeline presents an 8-bit index on a separate lookup port and, one clock later, receives the colour widened to 8 bits per channel. An optional swap exchanges the red and blue outputs for panels wired in the opposite channel order.

The block has no state machine. Its only sequencing is a single register stage on each read path: one for the bus read-back and one for the lookup. Storage is one array with one write port and two read ports. Both read ports return the value held before a same-cycle write.

Top module: `pal_ram_top`

## Requirements
- R1: A write with `bus_wr` high to a byte address inside 0x200..0x3FF stores `bus_wdata` in word (addr-0x200)>>2. Address bits [1:0] are ignored. A read with `bus_rd` high returns that raw 32-bit word on `bus_rdata`, with `bus_rvalid` high, in the cycle after the request.
- R2: A write outside the window changes no word. A read outside the window returns 0 with `bus_rvalid` high.
- R3: Lookup index i selects word i>>1. An even index takes bits [15:0] and an odd index takes bits [31:16].
- R4: Within an entry, bits [4:0] are red, bits [9:5] are green and bits [14:10] are blue. Each 5-bit channel appears on the 8-bit output shifted left by 3, with bits [2:0] zero.
- R5: Entry bit 15 (intensity) has no effect on any colour output.
- R6: When `lk_bgr` is high with the request, the red output carries the blue field and the blue output carries the red field. Green is unchanged.
- R7: `px_valid` is high in exactly the cycle after a cycle with `lk_req` high. The colour outputs change only after a request and hold their value otherwise.
- R8: When a write and a lookup address the same word in the same cycle, the lookup returns the old word. A later lookup returns the new word.
- R9: After reset, `px_valid`, `bus_rvalid`, `bus_rdata` and all colour outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after `bus_rd` |
| bus_rvalid | output | 1 | Read data valid |
| lk_req | input | 1 | Lookup request |
| lk_index | input | 8 | Colour index |
| lk_bgr | input | 1 | Swap red and blue for this request |
| px_valid | output | 1 | Colour outputs updated this cycle |
| px_red | output | 8 | Red channel |
| px_green | output | 8 | Green channel |
| px_blue | output | 8 | Blue channel |

## Verification
The hardest case to reach is the same-cycle collision between a software write and a pixel lookup on one word. The ports give no sign of it: the lookup result simply shows either old or new data. The bench stages it by raising `bus_wr` and `lk_req` on the same falling edge for one word, with the new entry chosen so that every channel differs from the old one. It then checks the old colour first and the new colour on a second lookup. The intensity bit is exercised by entries that differ only in bit 15, and the two halves of a word hold distinct colours, so a halfword mix-up cannot go unnoticed.

// File: rtl/pal_pkg.sv
package pal_pkg;
    parameter int PAL_WORDS  = 128;
    parameter int WORD_W     = 32;
    parameter int ADDR_W     = 12;
    parameter int BASE_BYTE  = 'h200;
    parameter int CH_W       = 5;
    parameter int OUT_W      = 8;
    localparam int ENTRY_W   = WORD_W / 2;
    localparam int WIDX_W    = $clog2(PAL_WORDS);
    localparam int INDEX_W   = WIDX_W + 1;
    localparam int PAD_W     = OUT_W - CH_W;

    typedef struct packed {
        logic [OUT_W-1:0] red;
        logic [OUT_W-1:0] green;
        logic [OUT_W-1:0] blue;
    } rgb_t;

    function automatic logic [OUT_W-1:0] widen(input logic [CH_W-1:0] ch);
        return {ch, {PAD_W{1'b0}}};
    endfunction
endpackage

// File: rtl/pal_decode.sv
module pal_decode
    import pal_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output logic              in_win,
    output logic [WIDX_W-1:0] word_idx
);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE_BYTE);
    localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(PAL_WORDS * 4);

    logic [ADDR_W-1:0] offset;
    logic [1:0]        unused_lsb;

    always_comb begin
        offset     = addr - BASE_A;
        in_win     = (addr >= BASE_A) && (offset < SPAN_A);
        word_idx   = offset[WIDX_W+1:2];
        unused_lsb = offset[1:0];
    end
endmodule

// File: rtl/pal_store.sv
module pal_store
    import pal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [WIDX_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              bre,
    input  logic [WIDX_W-1:0] baddr,
    output logic [WORD_W-1:0] bdata,
    input  logic              lre,
    input  logic [WIDX_W-1:0] laddr,
    output logic [WORD_W-1:0] ldata
);
    logic [WORD_W-1:0] mem [PAL_WORDS];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Read ports sample the array before the same-edge write lands.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bdata <= '0;
            ldata <= '0;
        end else begin
            if (bre) bdata <= mem[baddr];
            if (lre) ldata <= mem[laddr];
        end
    end
endmodule

// File: rtl/pal_expand.sv
module pal_expand
    import pal_pkg::*;
(
    input  logic [ENTRY_W-1:0] entry,
    input  logic               swap_rb,
    output rgb_t               color
);
    logic [CH_W-1:0] f_r, f_g, f_b;
    logic            unused_intensity;

    always_comb begin
        f_r              = entry[CH_W-1:0];
        f_g              = entry[2*CH_W-1:CH_W];
        f_b              = entry[3*CH_W-1:2*CH_W];
        unused_intensity = entry[ENTRY_W-1];
        color.green      = widen(f_g);
        if (swap_rb) begin
            color.red  = widen(f_b);
            color.blue = widen(f_r);
        end else begin
            color.red  = widen(f_r);
            color.blue = widen(f_b);
        end
    end
endmodule

// File: rtl/pal_ram_top.sv
module pal_ram_top
    import pal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    input  logic              lk_req,
    input  logic [INDEX_W-1:0] lk_index,
    input  logic              lk_bgr,
    output logic              px_valid,
    output logic [OUT_W-1:0]  px_red,
    output logic [OUT_W-1:0]  px_green,
    output logic [OUT_W-1:0]  px_blue
);
    logic              hit;
    logic [WIDX_W-1:0] widx;
    logic [WORD_W-1:0] bword, lword;
    logic              hit_q, hi_q, bgr_q;
    logic [ENTRY_W-1:0] entry;
    rgb_t              color;

    pal_decode u_dec (.addr(bus_addr), .in_win(hit), .word_idx(widx));

    pal_store u_mem (
        .clk(clk), .rst_n(rst_n),
        .we(bus_wr && hit), .waddr(widx), .wdata(bus_wdata),
        .bre(bus_rd && hit), .baddr(widx), .bdata(bword),
        .lre(lk_req), .laddr(lk_index[INDEX_W-1:1]), .ldata(lword)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            hit_q      <= 1'b0;
            px_valid   <= 1'b0;
            hi_q       <= 1'b0;
            bgr_q      <= 1'b0;
        end else begin
            bus_rvalid <= bus_rd;
            if (bus_rd) hit_q <= hit;
            px_valid <= lk_req;
            if (lk_req) begin
                hi_q  <= lk_index[0];
                bgr_q <= lk_bgr;
            end
        end
    end

    assign bus_rdata = hit_q ? bword : '0;
    assign entry     = hi_q ? lword[WORD_W-1:ENTRY_W] : lword[ENTRY_W-1:0];

    pal_expand u_exp (.entry(entry), .swap_rb(bgr_q), .color(color));

    assign px_red   = color.red;
    assign px_green = color.green;
    assign px_blue  = color.blue;
endmodule

// File: rtl/pal_ram_chk.sv
module pal_ram_chk
    import pal_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               bus_rd,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [WORD_W-1:0]  bus_rdata,
    input logic               bus_rvalid,
    input logic               lk_req,
    input logic               px_valid,
    input logic [OUT_W-1:0]   px_red,
    input logic [OUT_W-1:0]   px_green,
    input logic [OUT_W-1:0]   px_blue
);
    logic outside;
    assign outside = (int'(bus_addr) < BASE_BYTE) || (int'(bus_addr) >= BASE_BYTE + PAL_WORDS * 4);

    p_rvalid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);

    p_outside_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && outside) |=> (bus_rdata == '0));

    p_low_bits_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        px_valid |-> (px_red[2:0] == 3'b0 && px_green[2:0] == 3'b0 && px_blue[2:0] == 3'b0));

    p_valid_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> px_valid);

    p_valid_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !px_valid);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> ($stable(px_red) && $stable(px_green) && $stable(px_blue)));
endmodule

bind pal_ram_top pal_ram_chk u_chk (.*);

// File: tb/sim_pal_ram_top.sv
module sim_pal_ram_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        lk_req = 1'b0, lk_bgr = 1'b0;
    logic [7:0]  lk_index = '0;
    logic        px_valid;
    logic [7:0]  px_red, px_green, px_blue;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    pal_ram_top u0 (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] model(input logic [15:0] e, input bit bgr);
        logic [7:0] r, g, b;
        r = {e[4:0], 3'b000};
        g = {e[9:5], 3'b000};
        b = {e[14:10], 3'b000};
        return bgr ? {b, g, r} : {r, g, b};
    endfunction

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata; v = bus_rvalid;
    endtask

    task automatic look(input logic [7:0] i, input bit bgr, output logic [23:0] c, output logic v);
        @(negedge clk);
        lk_req = 1'b1; lk_index = i; lk_bgr = bgr;
        @(negedge clk);
        lk_req = 1'b0;
        c = {px_red, px_green, px_blue}; v = px_valid;
    endtask

    task automatic t_reset();
        check("R9 px_valid", 32'(px_valid), 0);
        check("R9 bus_rvalid", 32'(bus_rvalid), 0);
        check("R9 bus_rdata", bus_rdata, 0);
        check("R9 colour", 32'({px_red, px_green, px_blue}), 0);
    endtask

    task automatic t_readback();
        logic [31:0] d; logic v;
        wr(12'h200, 32'h801F_03E0);
        wr(12'h3FF, 32'hDEAD_BEEF);      // low bits ignored: word 127
        wr(12'h211, 32'h1234_5678);      // word 4
        rd(12'h200, d, v);
        check("R1 word0", d, 32'h801F_03E0);
        check("R1 rvalid", 32'(v), 1);
        rd(12'h3FC, d, v);
        check("R1 word127", d, 32'hDEAD_BEEF);
        rd(12'h212, d, v);
        check("R1 word4", d, 32'h1234_5678);
    endtask

    task automatic t_outside();
        logic [31:0] d; logic v;
        wr(12'h1FC, 32'hFFFF_FFFF);
        wr(12'h400, 32'hFFFF_FFFF);
        rd(12'h200, d, v);
        check("R2 word0 untouched", d, 32'h801F_03E0);
        rd(12'h3FC, d, v);
        check("R2 word127 untouched", d, 32'hDEAD_BEEF);
        rd(12'h1FC, d, v);
        check("R2 outside read zero", d, 0);
        check("R2 outside rvalid", 32'(v), 1);
        rd(12'h400, d, v);
        check("R2 above read zero", d, 0);
    endtask

    task automatic t_halves();
        logic [23:0] c; logic v;
        look(8'd0, 1'b0, c, v);
        check("R3 even entry", 32'(c), 32'(model(16'h03E0, 0)));
        check("R7 valid", 32'(v), 1);
        look(8'd1, 1'b0, c, v);
        check("R3 odd entry", 32'(c), 32'(model(16'h801F, 0)));
        look(8'd255, 1'b0, c, v);
        check("R3 index 255", 32'(c), 32'(model(16'hDEAD, 0)));
    endtask

    task automatic t_fields();
        logic [23:0] c; logic v;
        wr(12'h220, {16'h7C00, 16'h4631}); // word 8: hi blue max, lo r=17 g=17 b=17
        look(8'd16, 1'b0, c, v);
        check("R4 mixed fields", 32'(c), 32'h888888);
        look(8'd17, 1'b0, c, v);
        check("R4 blue only", 32'(c), 32'h0000F8);
    endtask

    task automatic t_intensity();
        logic [23:0] c0, c1; logic v;
        wr(12'h20C, {16'h9234, 16'h1234}); // word 3
        look(8'd6, 1'b0, c0, v);
        look(8'd7, 1'b0, c1, v);
        check("R5 intensity clear", 32'(c0), 32'(model(16'h1234, 0)));
        check("R5 intensity ignored", 32'(c1), 32'(c0));
    endtask

    task automatic t_swap();
        logic [23:0] c; logic v;
        look(8'd1, 1'b1, c, v);
        check("R6 swap red to blue", 32'(c), 32'h0000F8);
        look(8'd6, 1'b1, c, v);
        check("R6 swap", 32'(c), 32'(model(16'h1234, 1)));
    endtask

    task automatic t_timing();
        logic [23:0] c; logic v;
        look(8'd17, 1'b0, c, v);
        @(negedge clk);
        check("R7 valid drops", 32'(px_valid), 0);
        bus_wr = 1'b1; bus_addr = 12'h220; bus_wdata = 32'h0;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R7 colour holds", 32'({px_red, px_green, px_blue}), 32'h0000F8);
        check("R7 valid stays low", 32'(px_valid), 0);
    endtask

    task automatic t_collide();
        logic [23:0] c; logic v;
        wr(12'h214, {16'h0000, 16'h0421}); // word 5, entry 10 = 1,1,1
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 12'h214; bus_wdata = {16'h0000, 16'h7FFF};
        lk_req = 1'b1; lk_index = 8'd10; lk_bgr = 1'b0;
        @(negedge clk);
        bus_wr = 1'b0; lk_req = 1'b0;
        check("R8 old data", 32'({px_red, px_green, px_blue}), 32'h080808);
        look(8'd10, 1'b0, c, v);
        check("R8 new data", 32'(c), 32'hF8F8F8);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_readback();
        t_outside();
        t_halves();
        t_fields();
        t_intensity();
        t_swap();
        t_timing();
        t_collide();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule